// File: doc/BRIEF.md
# LED Matrix Scan and Flash Timer

This block produces the scan timing for an eight-character display. Each character is a 5x7 dot matrix. The fourteen row lines form two banks of seven. Bank 0 serves characters 0 to 3 and bank 1 serves characters 4 to 7. At any moment one row line is enabled. A 20-bit column bus carries the dots of the four characters in the active bank for that row.

For each row it asks an external glyph lookup for the dots. The lookup sees a bank number and a row number and returns 20 bits combinationally. A three-bit level input dims the display by shortening the time the columns are driven inside each row slot. The peak drive does not change. An internal divider produces a slow blink phase. A character whose bit is set in the flash map goes dark during the dark half of that phase, but only while flashing is globally enabled.

The block runs on a system clock. The display clock reaches it as one of two tick enables, an internal one and an external one, chosen by a select input. Tying the external tick of several displays together keeps their scanning and blinking in step. The reset is asynchronous and active low. The block releases it on the second clock edge after the reset input rises, and the first tick can take effect on the third.

Top module: `led_scan_timer`

## Requirements
- R1: While reset is low, and until the third rising clock edge after it rises, the block shows its reset state. In that state the scan is at slot 0 (row_en = 14'b1, look_bank = 0, look_row = 0), col_drv is zero, and the blink phase is visible with its divider count at zero.
- R2: Only the tick chosen by src_int advances the block (tick_int when src_int = 1, tick_ext when src_int = 0). Ticks on the other input leave the scan and the blink phase unchanged.
- R3: The scan slot runs 0 to 13 and wraps to 0. It advances after SLOT_TICKS selected ticks. For slot s, row_en has exactly bit s set, look_bank = s / 7 and look_row = s mod 7.
- R4: Bits [5k+4:5k] of col_drv carry bits [5k+4:5k] of look_dots for character 4*look_bank + k, with k from 0 to 3.
- R5: Each slot is made of SLOT_TICKS phases numbered from 0. In phase 0, the first phase of every slot, all columns are blank.
- R6: For level L (0 to 7), let N = ((7 - L) * (SLOT_TICKS - 1)) / 7, rounded down. Columns are driven only in phases 1 to N of a slot. Level 0 is full brightness.
- R7: The blink phase toggles after every FLASH_HALF selected ticks, starting visible. In the dark half, a character with flash_map bit set has its five columns forced to zero when flash_en = 1.
- R8: With flash_en = 0, the flash map and the blink phase have no effect on col_drv.
- R9: At level 7, col_drv stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal display-clock tick enable |
| tick_ext | input | 1 | External display-clock tick enable |
| src_int | input | 1 | 1 selects tick_int, 0 selects tick_ext |
| bright_lvl | input | 3 | Dimming level, 0 brightest, 7 dark |
| flash_en | input | 1 | Global enable for per-character blinking |
| flash_map | input | 8 | Per-character blink select, bit i for character i |
| look_bank | output | 1 | Bank being scanned, for the glyph lookup |
| look_row | output | 3 | Row within the bank, for the glyph lookup |
| look_dots | input | 20 | Dots returned for the four characters of the bank |
| row_en | output | 14 | One-hot row enable |
| col_drv | output | 20 | Column drive |

## Verification
A corrupted slot counter shows at once on row_en and on the lookup address, and the bench compares both on every clock. A wrong phase counter first moves the blank phase and the dimming window on col_drv. It can stay hidden at level 7, so the bench sweeps all levels. A wrong blink divider only shows when flash is enabled and a selected character crosses a half-period boundary, which is up to FLASH_HALF ticks later. The bench therefore keeps FLASH_HALF small and runs several half periods in every mode.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
  localparam int BANKS         = 2;
  localparam int ROWS_PER_BANK = 7;
  localparam int DIG_PER_BANK  = 4;
  localparam int DOT_COLS      = 5;
  localparam int LEVEL_W       = 3;
  localparam int SLOTS         = BANKS * ROWS_PER_BANK;
  localparam int DIGITS        = BANKS * DIG_PER_BANK;
  localparam int COL_W         = DIG_PER_BANK * DOT_COLS;
  localparam int SLOT_W        = $clog2(SLOTS);
  localparam int ROW_W         = $clog2(ROWS_PER_BANK);
  localparam int BANK_W        = (BANKS > 1) ? $clog2(BANKS) : 1;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import ledscan_pkg::*;
#(
  parameter int SLOT_TICKS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           adv,
  output slot_t                          slot,
  output logic [$clog2(SLOT_TICKS)-1:0]  phase,
  output logic [BANK_W-1:0]              bank,
  output logic [ROW_W-1:0]               row
);
  localparam int PH_W = $clog2(SLOT_TICKS);

  slot_t            slot_d;
  logic [PH_W-1:0]  phase_d;

  always_comb begin
    slot_d  = slot;
    phase_d = phase;
    if (adv) begin
      if (phase == PH_W'(SLOT_TICKS - 1)) begin
        phase_d = '0;
        slot_d  = (slot == slot_t'(SLOTS - 1)) ? '0 : slot + 1'b1;
      end else begin
        phase_d = phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '0;
      phase <= '0;
    end else if (adv) begin
      slot  <= slot_d;
      phase <= phase_d;
    end
  end

  assign bank = BANK_W'(32'(slot) / ROWS_PER_BANK);
  assign row  = ROW_W'(32'(slot) % ROWS_PER_BANK);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(slot) && $stable(phase)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && slot == slot_t'(SLOTS - 1) && phase == PH_W'(SLOT_TICKS - 1))
      |=> (slot == '0 && phase == '0));

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot) < SLOTS);
endmodule

// File: rtl/flash_div.sv
module flash_div #(
  parameter int FLASH_HALF = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic dark
);
  localparam int CNT_W = (FLASH_HALF > 1) ? $clog2(FLASH_HALF) : 1;

  logic [CNT_W-1:0] cnt, cnt_d;
  logic             dark_d;
  logic             wrap;

  assign wrap = (cnt == CNT_W'(FLASH_HALF - 1));

  always_comb begin
    cnt_d  = cnt + 1'b1;
    dark_d = dark;
    if (wrap) begin
      cnt_d  = '0;
      dark_d = ~dark;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dark <= 1'b0;
    end else if (adv) begin
      cnt  <= cnt_d;
      dark <= dark_d;
    end
  end

  assert_flash_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(dark));

  assert_flash_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap) |=> (dark != $past(dark)));

  assert_flash_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap) |=> $stable(dark));
endmodule

// File: rtl/col_gate.sv
module col_gate
  import ledscan_pkg::*;
#(
  parameter int SLOT_TICKS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SLOT_TICKS)-1:0] phase,
  input  logic [BANK_W-1:0]             bank,
  input  logic [COL_W-1:0]              dots,
  input  logic [LEVEL_W-1:0]            bright,
  input  logic                          flash_en,
  input  logic [DIGITS-1:0]             flash_map,
  input  logic                          dark,
  output logic [COL_W-1:0]              col
);
  localparam int PH_W   = $clog2(SLOT_TICKS);
  localparam int CW     = PH_W + 1;
  localparam int ACTIVE = SLOT_TICKS - 1;
  localparam int MAXL   = (1 << LEVEL_W) - 1;

  logic [CW-1:0]           on_cnt;
  logic                    lit;
  logic [DIG_PER_BANK-1:0] map_bank;
  logic [DIG_PER_BANK-1:0] hidden;

  always_comb begin
    on_cnt = CW'(((MAXL - int'(bright)) * ACTIVE) / MAXL);
    lit    = (phase != '0) && (({1'b0, phase} - CW'(1)) < on_cnt);
    map_bank = flash_map[DIG_PER_BANK * int'(bank) +: DIG_PER_BANK];
  end

  for (genvar k = 0; k < DIG_PER_BANK; k++) begin : g_digit
    assign hidden[k] = flash_en & map_bank[k] & dark;
    assign col[k*DOT_COLS +: DOT_COLS] =
      (lit && !hidden[k]) ? dots[k*DOT_COLS +: DOT_COLS] : '0;
  end

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> (col == '0));

  assert_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bright == '1) |-> (col == '0));

  assert_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_en && phase != '0 && bright == '0) |-> (col == dots));
endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer
  import ledscan_pkg::*;
#(
  parameter int SLOT_TICKS = 8,
  parameter int FLASH_HALF = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_int,
  input  logic                 tick_ext,
  input  logic                 src_int,
  input  logic [LEVEL_W-1:0]   bright_lvl,
  input  logic                 flash_en,
  input  logic [DIGITS-1:0]    flash_map,
  output logic [BANK_W-1:0]    look_bank,
  output logic [ROW_W-1:0]     look_row,
  input  logic [COL_W-1:0]     look_dots,
  output logic [SLOTS-1:0]     row_en,
  output logic [COL_W-1:0]     col_drv
);
  localparam int PH_W = $clog2(SLOT_TICKS);

  logic            rs1, rs2;
  logic            adv;
  slot_t           slot;
  logic [PH_W-1:0] phase;
  logic            dark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end
  end

  assign adv = src_int ? tick_int : tick_ext;

  scan_seq #(.SLOT_TICKS(SLOT_TICKS)) u_seq (
    .clk   (clk),
    .rst_n (rs2),
    .adv   (adv),
    .slot  (slot),
    .phase (phase),
    .bank  (look_bank),
    .row   (look_row)
  );

  flash_div #(.FLASH_HALF(FLASH_HALF)) u_flash (
    .clk   (clk),
    .rst_n (rs2),
    .adv   (adv),
    .dark  (dark)
  );

  col_gate #(.SLOT_TICKS(SLOT_TICKS)) u_gate (
    .clk       (clk),
    .rst_n     (rs2),
    .phase     (phase),
    .bank      (look_bank),
    .dots      (look_dots),
    .bright    (bright_lvl),
    .flash_en  (flash_en),
    .flash_map (flash_map),
    .dark      (dark),
    .col       (col_drv)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_row
    assign row_en[i] = (slot == slot_t'(i));
  end

  assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rs2)
    $onehot(row_en));

  assert_row_range_R3: assert property (@(posedge clk) disable iff (!rs2)
    32'(look_row) < ROWS_PER_BANK);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rs2 |-> (row_en == SLOTS'(1) && col_drv == '0));
endmodule

// File: tb/led_scan_timer_test.sv
module led_scan_timer_test;
  localparam int ST = 8;
  localparam int FH = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_int = 1'b0, tick_ext = 1'b0, src_int = 1'b1;
  logic [2:0]  bright_lvl = 3'd0;
  logic        flash_en = 1'b0;
  logic [7:0]  flash_map = 8'h00;
  logic [0:0]  look_bank;
  logic [2:0]  look_row;
  logic [19:0] look_dots;
  logic [13:0] row_en;
  logic [19:0] col_drv;

  int checks = 0, fails = 0;
  bit done = 0;
  bit gate_int = 1;
  string row_tag = "R3";

  always #5 clk = ~clk;

  led_scan_timer #(.SLOT_TICKS(ST), .FLASH_HALF(FH)) uut (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
    .src_int(src_int), .bright_lvl(bright_lvl), .flash_en(flash_en),
    .flash_map(flash_map), .look_bank(look_bank), .look_row(look_row),
    .look_dots(look_dots), .row_en(row_en), .col_drv(col_drv)
  );

  function automatic logic [19:0] pat(int b, int r);
    return 20'(((b * 7 + r + 1) * 32'h2D4B7) ^ 32'h9A3C5);
  endfunction

  assign look_dots = pat(int'(look_bank), int'(look_row));

  // behavioural reference model
  int m_slot, m_phase, m_fcnt, m_sync;
  bit m_dark;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 0; m_phase = 0; m_fcnt = 0; m_sync = 0; m_dark = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else if (src_int ? tick_int : tick_ext) begin
      m_phase++;
      if (m_phase == ST) begin
        m_phase = 0;
        m_slot = (m_slot + 1) % 14;
      end
      m_fcnt++;
      if (m_fcnt == FH) begin
        m_fcnt = 0;
        m_dark = !m_dark;
      end
    end
  end

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int b = m_slot / 7;
    int r = m_slot % 7;
    int n = ((7 - int'(bright_lvl)) * (ST - 1)) / 7;
    bit lit = (m_phase != 0) && (m_phase - 1 < n);
    logic [19:0] d = pat(b, r);
    logic [19:0] e = '0;
    bit any_hidden = 0;
    string ct;
    for (int k = 0; k < 4; k++) begin
      bit hid = flash_en && flash_map[b * 4 + k] && m_dark;
      if (hid) any_hidden = 1;
      if (lit && !hid) e[k*5 +: 5] = d[k*5 +: 5];
    end
    check(row_en == (14'(1) << m_slot), row_tag, "row_en", 32'(row_en), 32'(14'(1) << m_slot));
    check(look_bank == 1'(b) && look_row == 3'(r), row_tag, "lookup address",
          {28'(look_bank), look_row}, {28'(b), 3'(r)});
    if (m_phase == 0)          ct = "R5";
    else if (any_hidden)       ct = "R7";
    else if (bright_lvl == 7)  ct = "R9";
    else if (!flash_en)        ct = "R8";
    else if (bright_lvl != 0)  ct = "R6";
    else                       ct = "R4";
    check(col_drv == e, ct, "col_drv", 32'(col_drv), 32'(e));
  endtask

  task automatic step(int cyc);
    @(negedge clk);
    tick_int = gate_int && (cyc % 2 == 0);
    tick_ext = (cyc % 3 == 0);
    #1 compare();
  endtask

  initial begin
    // R1: reset state while held low
    repeat (3) @(negedge clk);
    #1;
    check(row_en == 14'd1, "R1", "row_en in reset", 32'(row_en), 32'd1);
    check(col_drv == 20'd0, "R1", "col_drv in reset", 32'(col_drv), 32'd0);
    check(look_bank == 1'b0 && look_row == 3'd0, "R1", "lookup in reset",
          {28'(look_bank), look_row}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 16; p++) begin
      src_int    = p[0];
      bright_lvl = 3'(p % 8);
      flash_en   = (p >= 4) ? p[1] : 1'b0;
      flash_map  = 8'hA5 ^ 8'(p * 37);
      gate_int   = 1'b1;
      row_tag    = "R3";
      if (p == 5 || p == 12) begin
        // R2: external ticks run but internal is selected and held idle
        src_int = 1'b1; gate_int = 1'b0; row_tag = "R2";
      end
      if (p == 10) begin
        flash_en = 1'b1; bright_lvl = 3'd0; flash_map = 8'hFF;
      end
      if (p == 9) begin
        // R1: mid-run reset restarts counters
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(row_en == 14'd1 && col_drv == 20'd0, "R1", "restart state",
              {12'(row_en), col_drv}, {12'd1, 20'd0});
        @(negedge clk);
        rst_n = 1'b1;
      end
      for (int c = 0; c < 500; c++) step(c);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule